// File: doc/BRIEF.md
# Two-Stack Execution Unit with Stepping and Indexed Address Registers

This block is the execution core of a 16-bit dual-stack processor. Operands live on a data stack and loop counts or saved values on a separate return stack. Neither stack is mapped into data memory. Each cycle the core takes one already-decoded opcode, with an immediate for literals, from an upstream sequencer. It updates its stacks and registers and uses a single-port synchronous data memory to load and store words.

Two scratch pointers, A and B, step through memory on each access. Each access can leave the pointer as it is, add one or subtract one. Two base registers, X and Y, address memory as base plus an index taken from the stack. This fits frame-relative locals and per-thread storage. A counted-loop opcode decrements the top of the return stack. It reports on its `loop_back` output whether the sequencer should jump back to the loop head.

Memory reads have one cycle of latency. Every load therefore holds off the next opcode for exactly one cycle, which is signalled by `ins_ready`. Stack misuse (pushing onto a full stack or popping from an empty one) is refused: the opcode has no effect, and a sticky flag for that stack is raised.

Top module: `tsc_core`

## Requirements
- R1: After reset both stacks are empty, `tos`, `nos` and `tor` read 0, both error flags are low and `ins_ready` is high.
- R2: LIT (code 1) pushes `ins_imm`. DUP (2) pushes a copy of the top. SWAP (3) exchanges the top two entries. ADD (4) pops two entries and pushes their sum modulo 2^16.
- R3: TOA (5), TOB (6), TOX (20) and TOY (21) pop the data-stack top into pointer A, B, X or Y. TOR (7) pops the data-stack top and pushes it onto the return stack.
- R4: Loads through A use codes 8/9/10 and loads through B use 11/12/13, in the order keep / post-increment / post-decrement. Each reads the word at the pointer, pushes it, and then steps the pointer by 0, +1 or -1 (wrapping).
- R5: An accepted load holds `ins_ready` low for exactly the next cycle. The loaded word is on `tos` after the clock edge that ends that stall cycle.
- R6: Stores through A use codes 14/15/16 and stores through B use 17/18/19, with the same keep/+1/-1 order. Each writes `tos` to the pointer address in a single `mem_we` cycle, pops it, and steps the pointer. Stores never stall.
- R7: Indexed access uses address base + `tos` modulo 2^16, with base X (LDX 22, STX 24) or Y (LDY 23, STY 25). A load replaces the index with the memory word, after the R5 stall. A store writes `nos` and pops both entries. X and Y are never changed by these accesses.
- R8: Writes to memory happen only during an accepted store. No write happens during a load stall.
- R9: NEXT (26) decrements the return-stack top. If the result is non-zero it keeps that result and pulses `loop_back` high for one cycle after the accepting edge. Otherwise it pops the return stack and `loop_back` stays low.
- R10: Stacks are 16 deep. An opcode that would overflow or underflow a stack changes no stack, pointer or memory word and does not stall. It sets that stack's sticky error flag (`d_err` or `r_err`), which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | An opcode is presented |
| ins_op | input | 5 | Opcode |
| ins_imm | input | 16 | Literal value for LIT |
| ins_ready | output | 1 | Opcode is accepted when high; low during a load stall |
| loop_back | output | 1 | One-cycle pulse: the last NEXT asks for a jump to the loop head |
| mem_addr | output | 16 | Data memory word address |
| mem_wdata | output | 16 | Data memory write word |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 16 | Read word, valid one cycle after the address |
| tos | output | 16 | Data stack top (0 when empty) |
| nos | output | 16 | Data stack second entry (0 when absent) |
| tor | output | 16 | Return stack top (0 when empty) |
| d_depth | output | 5 | Data stack occupancy |
| r_depth | output | 5 | Return stack occupancy |
| d_err | output | 1 | Sticky data stack overflow/underflow flag |
| r_err | output | 1 | Sticky return stack overflow/underflow flag |

## Verification
The checker watches the invariants that hold on every cycle:
- stack occupancy stays within its bound, and the error flags stay set once raised;
- a stall lasts exactly one cycle and follows every legal load;
- no memory write happens during a stall;
- `loop_back` only ever follows an accepted NEXT, and the return-stack depth is kept when it does.

The directed scenarios show the data-dependent results:
- arithmetic wrap-around;
- the exact address sequence of pointer stepping in each direction;
- base-plus-index address wrap;
- which word a store puts where;
- how many NEXT executions a given count yields;
- that a refused opcode leaves memory, pointers and stack contents untouched.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_LIT  = 5'd1,
        OP_DUP  = 5'd2,
        OP_SWAP = 5'd3,
        OP_ADD  = 5'd4,
        OP_TOA  = 5'd5,
        OP_TOB  = 5'd6,
        OP_TOR  = 5'd7,
        OP_LDA  = 5'd8,
        OP_LDAI = 5'd9,
        OP_LDAD = 5'd10,
        OP_LDB  = 5'd11,
        OP_LDBI = 5'd12,
        OP_LDBD = 5'd13,
        OP_STA  = 5'd14,
        OP_STAI = 5'd15,
        OP_STAD = 5'd16,
        OP_STB  = 5'd17,
        OP_STBI = 5'd18,
        OP_STBD = 5'd19,
        OP_TOX  = 5'd20,
        OP_TOY  = 5'd21,
        OP_LDX  = 5'd22,
        OP_LDY  = 5'd23,
        OP_STX  = 5'd24,
        OP_STY  = 5'd25,
        OP_NEXT = 5'd26
    } op_e;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

endpackage

// File: rtl/tsc_stack.sv
// Register-file stack. The caller guarantees that every pop/push request is
// legal; this module only moves entries and tracks occupancy.
module tsc_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pop_n,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  w_top,
    input  logic [W-1:0]  w_sec,
    output logic [CW-1:0] cnt,
    output logic [W-1:0]  top,
    output logic [W-1:0]  sec
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t          s_d, s_q;
    logic [CW-1:0] base_cnt;

    always_comb begin
        s_d      = s_q;
        base_cnt = s_q.cnt - CW'(pop_n);
        s_d.cnt  = base_cnt + CW'(push_n);
        for (int i = 0; i < DEPTH; i++) begin
            if (push_n != 2'd0 && CW'(i) + CW'(1) == s_d.cnt) begin
                s_d.ent[i] = w_top;
            end
            if (push_n == 2'd2 && CW'(i) + CW'(2) == s_d.cnt) begin
                s_d.ent[i] = w_sec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        top = '0;
        sec = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) + CW'(1) == s_q.cnt) top = s_q.ent[i];
            if (CW'(i) + CW'(2) == s_q.cnt) sec = s_q.ent[i];
        end
    end

    assign cnt = s_q.cnt;

endmodule

// File: rtl/tsc_agu.sv
// Address generation: pointer access with optional step, or base + index.
module tsc_agu
    import tsc_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] ptr_a,
    input  logic [DW-1:0] ptr_b,
    input  logic [DW-1:0] base_x,
    input  logic [DW-1:0] base_y,
    input  logic [DW-1:0] idx,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] ptr_nxt,
    output logic          upd_a,
    output logic          upd_b
);

    logic step_up;
    logic step_dn;

    always_comb begin
        ea      = '0;
        upd_a   = 1'b0;
        upd_b   = 1'b0;
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (op)
            OP_LDA, OP_STA:   ea = ptr_a;
            OP_LDAI, OP_STAI: begin ea = ptr_a; upd_a = 1'b1; step_up = 1'b1; end
            OP_LDAD, OP_STAD: begin ea = ptr_a; upd_a = 1'b1; step_dn = 1'b1; end
            OP_LDB, OP_STB:   ea = ptr_b;
            OP_LDBI, OP_STBI: begin ea = ptr_b; upd_b = 1'b1; step_up = 1'b1; end
            OP_LDBD, OP_STBD: begin ea = ptr_b; upd_b = 1'b1; step_dn = 1'b1; end
            OP_LDX, OP_STX:   ea = base_x + idx;
            OP_LDY, OP_STY:   ea = base_y + idx;
            default:          ea = '0;
        endcase
        if (step_up) begin
            ptr_nxt = ea + DW'(1);
        end else if (step_dn) begin
            ptr_nxt = ea - DW'(1);
        end else begin
            ptr_nxt = ea;
        end
    end

endmodule

// File: rtl/tsc_core.sv
module tsc_core
    import tsc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [4:0]    ins_op,
    input  logic [DW-1:0] ins_imm,
    output logic          ins_ready,
    output logic          loop_back,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] tos,
    output logic [DW-1:0] nos,
    output logic [DW-1:0] tor,
    output logic [CW-1:0] d_depth,
    output logic [CW-1:0] r_depth,
    output logic          d_err,
    output logic          r_err
);

    typedef struct packed {
        phase_e        ph;
        logic          wait_idx;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic          d_err;
        logic          r_err;
        logic          loop;
    } core_t;

    core_t c_d, c_q;
    op_e   op;

    logic [1:0]    d_pop, d_push, r_pop, r_push;
    logic [DW-1:0] d_w0, d_w1, r_w0;
    logic [DW-1:0] d_top, d_sec, r_top, r_unused_sec;
    logic [CW-1:0] d_cnt, r_cnt;
    logic [DW-1:0] ea, ptr_nxt, tor_dec;
    logic          upd_a, upd_b;
    logic          d_room, d_has1, d_has2, r_room, r_has1;

    assign op = op_e'(ins_op);

    tsc_stack #(.W(DW), .DEPTH(DEPTH)) u_dstk (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop_n  (d_pop),
        .push_n (d_push),
        .w_top  (d_w0),
        .w_sec  (d_w1),
        .cnt    (d_cnt),
        .top    (d_top),
        .sec    (d_sec)
    );

    tsc_stack #(.W(DW), .DEPTH(DEPTH)) u_rstk (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop_n  (r_pop),
        .push_n (r_push),
        .w_top  (r_w0),
        .w_sec  (r_w0),
        .cnt    (r_cnt),
        .top    (r_top),
        .sec    (r_unused_sec)
    );

    tsc_agu #(.DW(DW)) u_agu (
        .op      (op),
        .ptr_a   (c_q.a),
        .ptr_b   (c_q.b),
        .base_x  (c_q.x),
        .base_y  (c_q.y),
        .idx     (d_top),
        .ea      (ea),
        .ptr_nxt (ptr_nxt),
        .upd_a   (upd_a),
        .upd_b   (upd_b)
    );

    always_comb begin
        c_d       = c_q;
        c_d.loop  = 1'b0;
        d_pop     = 2'd0;
        d_push    = 2'd0;
        d_w0      = d_top;
        d_w1      = d_sec;
        r_pop     = 2'd0;
        r_push    = 2'd0;
        r_w0      = r_top;
        mem_we    = 1'b0;
        mem_wdata = d_top;
        d_room    = d_cnt < CW'(DEPTH);
        d_has1    = d_cnt >= CW'(1);
        d_has2    = d_cnt >= CW'(2);
        r_room    = r_cnt < CW'(DEPTH);
        r_has1    = r_cnt >= CW'(1);
        tor_dec   = r_top - DW'(1);

        if (c_q.ph == PH_WAIT) begin
            // read word arrives this cycle: push it, or replace the index
            c_d.ph = PH_RUN;
            d_w0   = mem_rdata;
            d_push = 2'd1;
            if (c_q.wait_idx) d_pop = 2'd1;
        end else if (ins_valid) begin
            unique case (op)
                OP_LIT: begin
                    if (d_room) begin d_push = 2'd1; d_w0 = ins_imm; end
                    else c_d.d_err = 1'b1;
                end
                OP_DUP: begin
                    if (d_room && d_has1) d_push = 2'd1;
                    else c_d.d_err = 1'b1;
                end
                OP_SWAP: begin
                    if (d_has2) begin
                        d_pop = 2'd2; d_push = 2'd2; d_w0 = d_sec; d_w1 = d_top;
                    end else c_d.d_err = 1'b1;
                end
                OP_ADD: begin
                    if (d_has2) begin
                        d_pop = 2'd2; d_push = 2'd1; d_w0 = d_top + d_sec;
                    end else c_d.d_err = 1'b1;
                end
                OP_TOA, OP_TOB, OP_TOX, OP_TOY: begin
                    if (d_has1) begin
                        d_pop = 2'd1;
                        if (op == OP_TOA) c_d.a = d_top;
                        if (op == OP_TOB) c_d.b = d_top;
                        if (op == OP_TOX) c_d.x = d_top;
                        if (op == OP_TOY) c_d.y = d_top;
                    end else c_d.d_err = 1'b1;
                end
                OP_TOR: begin
                    if (d_has1 && r_room) begin
                        d_pop = 2'd1; r_push = 2'd1; r_w0 = d_top;
                    end else begin
                        if (!d_has1) c_d.d_err = 1'b1;
                        if (!r_room) c_d.r_err = 1'b1;
                    end
                end
                OP_LDA, OP_LDAI, OP_LDAD, OP_LDB, OP_LDBI, OP_LDBD: begin
                    if (d_room) begin
                        c_d.ph       = PH_WAIT;
                        c_d.wait_idx = 1'b0;
                        if (upd_a) c_d.a = ptr_nxt;
                        if (upd_b) c_d.b = ptr_nxt;
                    end else c_d.d_err = 1'b1;
                end
                OP_LDX, OP_LDY: begin
                    if (d_has1) begin
                        c_d.ph       = PH_WAIT;
                        c_d.wait_idx = 1'b1;
                    end else c_d.d_err = 1'b1;
                end
                OP_STA, OP_STAI, OP_STAD, OP_STB, OP_STBI, OP_STBD: begin
                    if (d_has1) begin
                        d_pop  = 2'd1;
                        mem_we = 1'b1;
                        if (upd_a) c_d.a = ptr_nxt;
                        if (upd_b) c_d.b = ptr_nxt;
                    end else c_d.d_err = 1'b1;
                end
                OP_STX, OP_STY: begin
                    if (d_has2) begin
                        d_pop     = 2'd2;
                        mem_we    = 1'b1;
                        mem_wdata = d_sec;
                    end else c_d.d_err = 1'b1;
                end
                OP_NEXT: begin
                    if (r_has1) begin
                        r_pop = 2'd1;
                        if (tor_dec != '0) begin
                            r_push   = 2'd1;
                            r_w0     = tor_dec;
                            c_d.loop = 1'b1;
                        end
                    end else c_d.r_err = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_addr  = ea;
    assign ins_ready = (c_q.ph == PH_RUN);
    assign loop_back = c_q.loop;
    assign tos       = d_top;
    assign nos       = d_sec;
    assign tor       = r_top;
    assign d_depth   = d_cnt;
    assign r_depth   = r_cnt;
    assign d_err     = c_q.d_err;
    assign r_err     = c_q.r_err;

endmodule

// File: rtl/tsc_core_chk.sv
module tsc_core_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ins_valid,
    input logic [4:0]    ins_op,
    input logic          ins_ready,
    input logic          loop_back,
    input logic          mem_we,
    input logic [CW-1:0] d_depth,
    input logic [CW-1:0] r_depth,
    input logic          d_err,
    input logic          r_err
);

    a_r10_d_bound: assert property (@(posedge clk) disable iff (!rst_n)
        d_depth <= CW'(DEPTH));

    a_r10_r_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_depth <= CW'(DEPTH));

    a_r10_d_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        d_err |=> d_err);

    a_r10_r_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_err |=> r_err);

    a_r5_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |=> ins_ready);

    a_r5_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_op >= 5'd8 && ins_op <= 5'd13
         && d_depth != CW'(DEPTH)) |=> !ins_ready);

    a_r8_no_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |-> !mem_we);

    a_r9_loop_source: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |-> $past(ins_valid && ins_ready && ins_op == 5'd26));

    a_r9_loop_depth: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |-> $stable(r_depth));

endmodule

bind tsc_core tsc_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_op    (ins_op),
    .ins_ready (ins_ready),
    .loop_back (loop_back),
    .mem_we    (mem_we),
    .d_depth   (d_depth),
    .r_depth   (r_depth),
    .d_err     (d_err),
    .r_err     (r_err)
);

// File: tb/tsc_core_tb_top.sv
`timescale 1ns/1ps
module tsc_core_tb_top;

    localparam logic [4:0] C_LIT = 5'd1,  C_DUP = 5'd2,  C_SWAP = 5'd3, C_ADD = 5'd4;
    localparam logic [4:0] C_TOA = 5'd5,  C_TOB = 5'd6,  C_TOR = 5'd7;
    localparam logic [4:0] C_LDA = 5'd8,  C_LDAI = 5'd9, C_LDAD = 5'd10;
    localparam logic [4:0] C_LDB = 5'd11, C_LDBI = 5'd12;
    localparam logic [4:0] C_STAI = 5'd15, C_STBD = 5'd19;
    localparam logic [4:0] C_TOX = 5'd20, C_TOY = 5'd21, C_LDX = 5'd22, C_LDY = 5'd23;
    localparam logic [4:0] C_STY = 5'd25, C_NEXT = 5'd26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [4:0]  ins_op = '0;
    logic [15:0] ins_imm = '0;
    logic        ins_ready, loop_back, mem_we, d_err, r_err;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, tos, nos, tor;
    logic [4:0]  d_depth, r_depth;

    logic [15:0] bmem [0:255];
    int          wr_n = 0;
    logic [15:0] wr_a, wr_d;
    int          n_chk = 0;
    int          n_fail = 0;
    int          last_stall = 0;

    always #10 clk = ~clk;

    tsc_core dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_imm(ins_imm), .ins_ready(ins_ready), .loop_back(loop_back),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .tos(tos), .nos(nos), .tor(tor),
        .d_depth(d_depth), .r_depth(r_depth), .d_err(d_err), .r_err(r_err)
    );

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 16'h5A00 | 16'(i);
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
            wr_n = wr_n + 1;
            wr_a = mem_addr;
            wr_d = mem_wdata;
        end
        mem_rdata <= bmem[mem_addr[7:0]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] op, input logic [15:0] imm);
        ins_op = op; ins_imm = imm; ins_valid = 1'b1;
        @(posedge clk); #1;
        ins_valid = 1'b0;
        @(negedge clk);
        last_stall = 0;
        while (!ins_ready && last_stall < 4) begin
            last_stall++;
            @(negedge clk);
        end
    endtask

    task automatic op0(input logic [4:0] op);
        issue(op, 16'h0);
    endtask

    task automatic lit(input logic [15:0] v);
        issue(C_LIT, v);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; ins_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        reset_dut();
        chk("R1", "tos", tos, 0);
        chk("R1", "nos", nos, 0);
        chk("R1", "tor", tor, 0);
        chk("R1", "depths", {d_depth, r_depth}, 0);
        chk("R1", "errs", {d_err, r_err}, 0);
        chk("R1", "ready", ins_ready, 1);
    endtask

    task automatic t_arith();
        reset_dut();
        lit(16'd5); lit(16'd7);
        chk("R2", "lit tos/nos", {tos, nos}, {16'd7, 16'd5});
        op0(C_SWAP);
        chk("R2", "swap", {tos, nos}, {16'd5, 16'd7});
        op0(C_ADD);
        chk("R2", "add", {tos, 11'd0, d_depth}, {16'd12, 16'd1});
        op0(C_DUP);
        chk("R2", "dup", {tos, nos, 11'd0, d_depth}, {16'd12, 16'd12, 16'd2});
        lit(16'hFFFF); op0(C_ADD);
        chk("R2", "add wrap", tos, 16'h000B);
        chk("R2", "no error", d_err, 0);
    endtask

    task automatic t_ptr_ab();
        int w0;
        reset_dut();
        lit(16'h0010); op0(C_TOA);
        chk("R3", "toa pops", d_depth, 0);
        w0 = wr_n;
        lit(16'hAAAA); op0(C_STAI);
        chk("R6", "store a+ stall", last_stall, 0);
        chk("R6", "store a+ addr/data", {wr_a, wr_d}, {16'h0010, 16'hAAAA});
        chk("R6", "store pops", d_depth, 0);
        lit(16'hBBBB); op0(C_STAI);
        chk("R6", "store a+ stepped", {wr_a, wr_d}, {16'h0011, 16'hBBBB});
        chk("R8", "write count", wr_n - w0, 2);
        lit(16'h0011); op0(C_TOA);
        op0(C_LDAD);
        chk("R5", "load stall", last_stall, 1);
        chk("R4", "load a- first", tos, 16'hBBBB);
        op0(C_LDAD);
        chk("R4", "load a- second", tos, 16'hAAAA);
        op0(C_LDA);
        chk("R4", "load a keep", tos, 16'h5A0F);
        op0(C_LDA);
        chk("R4", "load a keep again", tos, 16'h5A0F);
        chk("R8", "no write on load", wr_n - w0, 2);
        lit(16'h0020); op0(C_TOB);
        op0(C_LDBI);
        chk("R4", "load b+ first", tos, 16'h5A20);
        op0(C_LDBI);
        chk("R4", "load b+ second", tos, 16'h5A21);
        op0(C_LDB);
        chk("R4", "load b keep", tos, 16'h5A22);
        lit(16'h1234); op0(C_STBD);
        chk("R6", "store b- addr/data", {wr_a, wr_d}, {16'h0022, 16'h1234});
        op0(C_LDB);
        chk("R6", "b decremented", tos, 16'h5A21);
    endtask

    task automatic t_indexed();
        int w0;
        reset_dut();
        lit(16'h0040); op0(C_TOX);
        lit(16'h0080); op0(C_TOY);
        chk("R3", "tox/toy pop", d_depth, 0);
        lit(16'd3); op0(C_LDX);
        chk("R7", "ldx stall", last_stall, 1);
        chk("R7", "ldx value", {tos, 11'd0, d_depth}, {16'h5A43, 16'd1});
        w0 = wr_n;
        lit(16'h5555); lit(16'd2); op0(C_STY);
        chk("R7", "sty addr/data", {wr_a, wr_d}, {16'h0082, 16'h5555});
        chk("R7", "sty pops two", d_depth, 1);
        chk("R8", "one write", wr_n - w0, 1);
        lit(16'd2); op0(C_LDY);
        chk("R7", "ldy readback", tos, 16'h5555);
        lit(16'd3); op0(C_LDX);
        chk("R8", "x unchanged", tos, 16'h5A43);
        lit(16'hFFF0); op0(C_TOX);
        lit(16'h0015); op0(C_LDX);
        chk("R7", "index wrap", tos, 16'h5A05);
    endtask

    task automatic t_loop();
        reset_dut();
        lit(16'd3); op0(C_TOR);
        chk("R3", "tor push", {tor, 11'd0, r_depth, 11'd0, d_depth},
            {16'd3, 16'd1, 16'd0});
        op0(C_NEXT);
        chk("R9", "next 1 loop", {15'd0, loop_back, tor}, {16'd1, 16'd2});
        @(negedge clk);
        chk("R9", "loop pulse ends", loop_back, 0);
        op0(C_NEXT);
        chk("R9", "next 2 loop", {15'd0, loop_back, tor}, {16'd1, 16'd1});
        op0(C_NEXT);
        chk("R9", "next 3 exit", {15'd0, loop_back, 11'd0, r_depth}, {16'd0, 16'd0});
        chk("R9", "no r_err", r_err, 0);
    endtask

    task automatic t_errors();
        int w0;
        reset_dut();
        op0(C_ADD);
        chk("R10", "underflow flag", {d_err, d_depth}, {1'b1, 5'd0});
        w0 = wr_n;
        op0(C_STAI);
        chk("R10", "no write on underflow", wr_n - w0, 0);
        op0(C_NEXT);
        chk("R10", "r underflow", {r_err, loop_back}, {1'b1, 1'b0});
        reset_dut();
        for (int i = 0; i < 16; i++) lit(16'h0100 + 16'(i));
        lit(16'hDEAD);
        chk("R10", "overflow refused", {d_err, 11'd0, d_depth, tos}, {1'b1, 16'd16, 16'h010F});
        lit(16'h0030); // refused again, stack still full
        op0(C_LDAI);
        chk("R10", "full load no stall", last_stall, 0);
        chk("R10", "full load tos", {11'd0, d_depth, tos}, {16'd16, 16'h010F});
        reset_dut();
        lit(16'h0050); op0(C_TOA);
        op0(C_LDAI); op0(C_LDAI);
        chk("R4", "a stepped twice", tos, 16'h5A51);
        for (int i = 0; i < 14; i++) lit(16'(i));
        op0(C_LDAI);
        chk("R10", "refused load", {d_err, 11'd0, d_depth}, {1'b1, 16'd16});
        reset_dut();
        for (int i = 0; i < 16; i++) begin lit(16'(i)); op0(C_TOR); end
        lit(16'd99); op0(C_TOR);
        chk("R10", "r overflow", {r_err, d_err, 6'd0, r_depth, 11'd0, d_depth},
            {1'b1, 1'b0, 11'd16, 16'd1});
        chk("R10", "r top kept", tor, 16'd15);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_arith();
        t_ptr_ab();
        t_indexed();
        t_loop();
        t_errors();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule